// File: doc/BRIEF.md
# Ternary Search Table with Lowest-Index Priority

This block is a content-addressable table of `ENTRIES` words, each `WIDTH` bits wide (512 by 64 by default). A host side reaches any word by address to write it, read it back, or change its validity flag. A flush command clears every validity flag at once. A separate search side presents a key and a care-mask on any cycle. Every valid word is compared against the key at the same time, but only on the bit positions the mask enables. The lowest-numbered matching word is reported as the result.

The host port and the search port are independent, so both may be active in the same cycle. A search always sees the table as it stood before that cycle's host command takes effect. Search results and read data are registered and appear one cycle after their request. Reset is an active-low asynchronous input whose release is synchronised inside the block.

Top module: `tcam_search`

## Requirements
- R1: After reset, `srch_done`, `srch_hit` and `rd_done` are 0, and every word is invalid, so a search with an all-zero mask misses.
- R2: Host command 2 (write) stores `host_wdata` at `host_addr` and marks that word valid. Host command 1 (read) returns the stored word on `rd_data` and its validity flag on `rd_vld`, with `rd_done` high, in the next cycle.
- R3: A word matches when it equals `srch_key` on every bit position where `srch_mask` is 1. Bit positions where `srch_mask` is 0 take no part in the comparison.
- R4: An invalid word never matches. Host command 4 clears the validity flag of the addressed word and host command 3 sets it; neither changes the stored data.
- R5: When several words match, `srch_idx` reports the lowest matching address.
- R6: `srch_done` is high in exactly the cycle after a cycle with `srch_req` high. In cycles without a search, `srch_hit` and `srch_idx` hold their last values.
- R7: A search in the same cycle as a write to a word compares against that word's contents from before the write.
- R8: Host command 5 (flush) clears every validity flag in one cycle. A search in the same cycle still sees the flags from before the flush.
- R9: On a miss, `srch_hit` is 0 and `srch_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd | input | 3 | 0 idle, 1 read, 2 write, 3 set valid, 4 clear valid, 5 flush, others idle |
| host_addr | input | $clog2(ENTRIES) | Word address for host commands |
| host_wdata | input | WIDTH | Data for a write |
| rd_done | output | 1 | Read data valid this cycle |
| rd_data | output | WIDTH | Word returned by a read |
| rd_vld | output | 1 | Validity flag of the word returned by a read |
| srch_req | input | 1 | Start a search this cycle |
| srch_key | input | WIDTH | Search key |
| srch_mask | input | WIDTH | 1 = bit position is compared |
| srch_done | output | 1 | Search result valid this cycle |
| srch_hit | output | 1 | Last search found a match |
| srch_idx | output | $clog2(ENTRIES) | Lowest matching address of the last search |

## Verification
The bench builds the block with 16 words of 16 bits. At that size every word can be loaded with a distinct, predictable pattern. Masks can then be chosen so that a single word matches, every word matches, or none matches, which exercises the priority order across the whole table and both the lowest and highest address. The same small size lets single-word clears, a full flush and same-cycle write-and-search be checked against a model the bench keeps of all contents.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [2:0] {
    HC_IDLE  = 3'd0,
    HC_READ  = 3'd1,
    HC_WRITE = 3'd2,
    HC_SETV  = 3'd3,
    HC_CLRV  = 3'd4,
    HC_FLUSH = 3'd5
  } host_cmd_e;
endpackage

// File: rtl/tcam_store.sv
module tcam_store
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int WIDTH   = 64,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  ent_data [ENTRIES],
  output logic [ENTRIES-1:0] ent_valid,
  output logic              rd_done,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_vld
);

  logic [ENTRIES-1:0] valid_d, valid_q;
  logic               rd_en;
  logic [WIDTH-1:0]   rd_data_d;
  logic               rd_vld_d;

  // validity flags: next state
  always_comb begin
    valid_d = valid_q;
    case (cmd)
      HC_WRITE, HC_SETV: valid_d[addr] = 1'b1;
      HC_CLRV:           valid_d[addr] = 1'b0;
      HC_FLUSH:          valid_d       = '0;
      default:           valid_d       = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign ent_valid = valid_q;

  // data words: one register per word with its own write enable
  for (genvar e = 0; e < ENTRIES; e++) begin : g_word
    logic             wr_en;
    logic [WIDTH-1:0] word_q;
    assign wr_en = (cmd == HC_WRITE) && (addr == ADDR_W'(e));
    always_ff @(posedge clk) begin
      if (wr_en) word_q <= wdata;
    end
    assign ent_data[e] = word_q;
  end

  // read path
  assign rd_en     = (cmd == HC_READ);
  assign rd_data_d = ent_data[addr];
  assign rd_vld_d  = valid_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done <= 1'b0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_done <= rd_en;
      if (rd_en) begin
        rd_data <= rd_data_d;
        rd_vld  <= rd_vld_d;
      end
    end
  end

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int ENTRIES = 512,
  parameter int WIDTH   = 64
) (
  input  logic [WIDTH-1:0]   ent_data [ENTRIES],
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [WIDTH-1:0]   key,
  input  logic [WIDTH-1:0]   mask,
  output logic [ENTRIES-1:0] match
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff     = (ent_data[e] ^ key) & mask;
    assign match[e] = ent_valid[e] && (diff == '0);
  end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int ENTRIES = 512,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [ADDR_W-1:0]  idx
);

  assign any = |match;

  // scan from the top so the lowest set bit is written last
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = ADDR_W'(i);
    end
  end

endmodule

// File: rtl/tcam_search.sv
module tcam_search #(
  parameter int ENTRIES = 512,
  parameter int WIDTH   = 64,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WIDTH-1:0]  host_wdata,
  output logic              rd_done,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_vld,
  input  logic              srch_req,
  input  logic [WIDTH-1:0]  srch_key,
  input  logic [WIDTH-1:0]  srch_mask,
  output logic              srch_done,
  output logic              srch_hit,
  output logic [ADDR_W-1:0] srch_idx
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [WIDTH-1:0]   ent_data [ENTRIES];
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [ADDR_W-1:0]  low_idx;

  tcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd       (host_cmd),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .rd_vld    (rd_vld)
  );

  tcam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .key       (srch_key),
    .mask      (srch_mask),
    .match     (match_vec)
  );

  tcam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .match (match_vec),
    .any   (any_match),
    .idx   (low_idx)
  );

  // search result: next state
  logic              done_d, hit_d;
  logic [ADDR_W-1:0] idx_d;

  always_comb begin
    done_d = srch_req;
    hit_d  = srch_hit;
    idx_d  = srch_idx;
    if (srch_req) begin
      hit_d = any_match;
      idx_d = low_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      srch_done <= 1'b0;
      srch_hit  <= 1'b0;
      srch_idx  <= '0;
    end else begin
      srch_done <= done_d;
      srch_hit  <= hit_d;
      srch_idx  <= idx_d;
    end
  end

endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 512,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [2:0]         host_cmd,
  input logic               srch_req,
  input logic               srch_done,
  input logic               srch_hit,
  input logic [ADDR_W-1:0]  srch_idx,
  input logic               rd_done,
  input logic [ENTRIES-1:0] match_vec
);

  logic [ENTRIES-1:0] match_q;
  always_ff @(posedge clk) match_q <= match_vec;

  // R6
  srch_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srch_req |=> srch_done);

  // R6
  srch_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !srch_req |=> (!srch_done && $stable(srch_hit) && $stable(srch_idx)));

  // R2
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_cmd == HC_READ) |=> rd_done);

  // R5
  lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (srch_done && srch_hit) |->
      (match_q[srch_idx] && ((match_q & ~({ENTRIES{1'b1}} << srch_idx)) == '0)));

  // R3
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srch_done |-> (srch_hit == (match_q != '0)));

  // R8
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((host_cmd == HC_FLUSH) && !srch_req) ##1 (srch_req && (host_cmd != HC_WRITE) && (host_cmd != HC_SETV))
      |=> !srch_hit);

  // R9
  miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (srch_done && !srch_hit) |-> (srch_idx == '0));

endmodule

bind tcam_search tcam_search_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .host_cmd   (host_cmd),
  .srch_req   (srch_req),
  .srch_done  (srch_done),
  .srch_hit   (srch_hit),
  .srch_idx   (srch_idx),
  .rd_done    (rd_done),
  .match_vec  (match_vec)
);

// File: tb/tcam_search_tb.sv
`timescale 1ns/1ps
module tcam_search_tb;
  localparam int N  = 16;
  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    host_cmd;
  logic [AW-1:0] host_addr;
  logic [W-1:0]  host_wdata;
  logic          rd_done, rd_vld;
  logic [W-1:0]  rd_data;
  logic          srch_req;
  logic [W-1:0]  srch_key, srch_mask;
  logic          srch_done, srch_hit;
  logic [AW-1:0] srch_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tcam_search #(.ENTRIES(N), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_cmd(host_cmd), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_done(rd_done), .rd_data(rd_data), .rd_vld(rd_vld),
    .srch_req(srch_req), .srch_key(srch_key), .srch_mask(srch_mask),
    .srch_done(srch_done), .srch_hit(srch_hit), .srch_idx(srch_idx)
  );

  // {key, mask, expected hit, expected index}
  localparam logic [36:0] VEC [9] = '{
    {16'hA53C, 16'hFFFF, 1'b1, 4'd3},
    {16'hA530, 16'hFFF0, 1'b1, 4'd3},
    {16'hA500, 16'hFF00, 1'b1, 4'd0},
    {16'h0070, 16'h00F0, 1'b1, 4'd7},
    {16'hA500, 16'h0000, 1'b1, 4'd0},
    {16'hB500, 16'hFF00, 1'b0, 4'd0},
    {16'h0009, 16'h000F, 1'b1, 4'd6},
    {16'hA5FF, 16'hFFFF, 1'b0, 4'd0},
    {16'hA5F0, 16'hFFFF, 1'b1, 4'd15}
  };

  function automatic logic [W-1:0] pat(input int i);
    return {8'hA5, 4'(i), 4'(15 - i)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_cmd = 3'd0; host_addr = '0; host_wdata = '0;
    srch_req = 1'b0; srch_key = '0; srch_mask = '0;
  endtask

  // drive for one cycle; outputs are sampled at the following negedge
  task automatic op(input logic [2:0] c, input int a, input logic [W-1:0] wd,
                    input logic s, input logic [W-1:0] k, input logic [W-1:0] m);
    host_cmd = c; host_addr = AW'(a); host_wdata = wd;
    srch_req = s; srch_key = k; srch_mask = m;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 srch_done", 32'(srch_done), 32'd0);
    check("R1 srch_hit", 32'(srch_hit), 32'd0);
    check("R1 rd_done", 32'(rd_done), 32'd0);
    op(3'd0, 0, '0, 1'b1, 16'h0000, 16'h0000);
    check("R1 all invalid miss", 32'(srch_hit), 32'd0);
    check("R9 miss idx", 32'(srch_idx), 32'd0);

    // load table
    for (int i = 0; i < N; i++) op(3'd2, i, pat(i), 1'b0, '0, '0);

    // R2 read back
    op(3'd1, 5, '0, 1'b0, '0, '0);
    check("R2 rd_done", 32'(rd_done), 32'd1);
    check("R2 rd_data", 32'(rd_data), 32'(pat(5)));
    check("R2 rd_vld", 32'(rd_vld), 32'd1);

    // R3 R5 R9 vector table
    for (int v = 0; v < 9; v++) begin
      op(3'd0, 0, '0, 1'b1, VEC[v][36:21], VEC[v][20:5]);
      check("R6 srch_done", 32'(srch_done), 32'd1);
      check("R3/R5 hit", 32'(srch_hit), 32'(VEC[v][4]));
      check("R5/R9 idx", 32'(srch_idx), 32'(VEC[v][3:0]));
    end

    // R6 hold when idle
    op(3'd0, 0, '0, 1'b0, '0, '0);
    check("R6 done low", 32'(srch_done), 32'd0);
    check("R6 hit held", 32'(srch_hit), 32'd1);
    check("R6 idx held", 32'(srch_idx), 32'd15);

    // R4 validity control
    op(3'd4, 0, '0, 1'b0, '0, '0);
    op(3'd0, 0, '0, 1'b1, 16'h0000, 16'h0000);
    check("R4 cleared skipped", 32'(srch_idx), 32'd1);
    op(3'd1, 0, '0, 1'b0, '0, '0);
    check("R4 data kept", 32'(rd_data), 32'(pat(0)));
    check("R4 flag clear", 32'(rd_vld), 32'd0);
    op(3'd3, 0, '0, 1'b0, '0, '0);
    op(3'd0, 0, '0, 1'b1, 16'h0000, 16'h0000);
    check("R4 set again", 32'(srch_idx), 32'd0);
    op(3'd4, 3, '0, 1'b0, '0, '0);
    op(3'd0, 0, '0, 1'b1, pat(3), 16'hFFFF);
    check("R4 invalid no match", 32'(srch_hit), 32'd0);

    // R7 write and search together
    op(3'd2, 2, 16'h1234, 1'b1, pat(2), 16'hFFFF);
    check("R7 old hit", 32'(srch_hit), 32'd1);
    check("R7 old idx", 32'(srch_idx), 32'd2);
    op(3'd0, 0, '0, 1'b1, pat(2), 16'hFFFF);
    check("R7 old gone", 32'(srch_hit), 32'd0);
    op(3'd0, 0, '0, 1'b1, 16'h1234, 16'hFFFF);
    check("R7 new idx", 32'(srch_idx), 32'd2);
    check("R7 new hit", 32'(srch_hit), 32'd1);

    // R8 flush
    op(3'd5, 0, '0, 1'b1, 16'h0000, 16'h0000);
    check("R8 same-cycle hit", 32'(srch_hit), 32'd1);
    op(3'd0, 0, '0, 1'b1, 16'h0000, 16'h0000);
    check("R8 flushed miss", 32'(srch_hit), 32'd0);
    op(3'd1, 4, '0, 1'b0, '0, '0);
    check("R8 flag cleared", 32'(rd_vld), 32'd0);

    finish_run();
  end

endmodule